// File: doc/BRIEF.md
# Two-wire bus bit timing engine

This block is the bit-level timing layer that sits under a two-wire (I2C) master sequencer. The sequencer hands it one request at a time: a start condition, a stop condition, a data bit to write, or a bit to read. The engine turns each request into open-drain pull-down enables for the clock and data lines. It times every edge in system clocks, using separately programmed clock-high, clock-low, data-setup and data-hold counts. A standard-mode setting uses equal high and low counts. A fast-mode setting uses a low count about twice the high count.

Both incoming line levels pass through a two-flop synchronizer. They then pass through a deglitcher that ignores pulses shorter than a programmed length. The clean levels are used inside the block and are also exported. The high phase of the clock is counted only once the clean clock line is seen high. A slave that holds the clock low therefore stretches the bit rather than shortening it.

Top module: `i2c_bit_phy`

## Requirements
- R1: After reset, both pull-down enables are 0, `req_ready` is 1, `done` is 0, `rx_bit` is 1 and both filtered lines are 1.
- R2: Each raw line passes through two synchronizer flops. A filtered line takes the synchronized level only after that level has differed from it for max(`cfg_spike_len`,1) consecutive clocks. Shorter pulses leave it unchanged.
- R3: The low phase starts on the clock edge that accepts a request. `sda_oe` takes its new value max(hold,1) clocks after acceptance. `scl_oe` is released no earlier than max(low, hold+setup) clocks after acceptance, and only once the filtered clock reads low while the engine is pulling it.
- R4: The high phase starts on the first edge at which the filtered clock is seen high after release, so clock stretching delays it. For write and read requests, `scl_oe` is asserted again max(high,1) clocks later.
- R5: For a start request (`req_op`=0), SDA is released in the low phase. SDA is driven low setup clocks into the high phase, and SCL is pulled low a further high clocks later.
- R6: For a stop request (`req_op`=1), SDA is driven low in the low phase and released setup clocks into the high phase. The request completes setup+high clocks into the high phase, with SCL left released.
- R7: For a write request (`req_op`=2), `sda_oe` is the inverse of `req_bit` and holds steady through the high phase.
- R8: For a read request (`req_op`=3), SDA is released. `rx_bit` takes the filtered SDA level on the edge that pulls SCL low and is changed by no other request.
- R9: `req_ready` is 1 only while idle. A request is taken only when `req_valid` and `req_ready` are both 1, and one raised while busy is ignored. `done` is a single-clock pulse on the edge that ends a request.
- R10: A programmed count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_scl_high | input | CW | Clock-high duration in clocks |
| cfg_scl_low | input | CW | Clock-low duration in clocks |
| cfg_sda_setup | input | CW | Data setup before a clock rise, in clocks |
| cfg_sda_hold | input | CW | Data hold after a clock fall, in clocks |
| cfg_spike_len | input | FW | Deglitch length in clocks |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| req_bit | input | 1 | Data bit for a write |
| req_ready | output | 1 | Engine idle, able to accept |
| done | output | 1 | One-clock pulse at the end of a request |
| rx_bit | output | 1 | Last bit captured by a read |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| scl_in | input | 1 | Raw clock line level |
| sda_in | input | 1 | Raw data line level |
| scl_filt | output | 1 | Deglitched clock line level |
| sda_filt | output | 1 | Deglitched data line level |

## Verification
A wrong phase or counter value shows up as an enable edge that moves by one or more clocks. It appears on `scl_oe` or `sda_oe` within the same request, usually before `done`. A deglitcher run count that is off shifts `scl_filt`/`sda_filt` by a clock, or lets a short pulse through. That in turn moves the start of the high phase or corrupts `rx_bit` at the end of the read. The bench compares every output against a timestamp-based model on every clock, so any such slip is seen in the cycle it happens.

// File: rtl/bit_phy_pkg.sv
package bit_phy_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] len_i,
  input  logic          raw_i,
  output logic          filt_o
);
  logic          s1_q, s2_q, filt_q, filt_d;
  logic [FW-1:0] run_q, run_d, len_eff;

  assign len_eff = (len_i == '0) ? {{(FW-1){1'b0}}, 1'b1} : len_i;

  always_comb begin
    filt_d = filt_q;
    run_d  = run_q;
    if (s2_q == filt_q) begin
      run_d = '0;
    end else if (run_q >= len_eff - 1'b1) begin
      filt_d = s2_q;
      run_d  = '0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      run_q  <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      filt_q <= filt_d;
      run_q  <= run_d;
    end
  end

  assign filt_o = filt_q;

  // R2: the filtered level only ever moves to the synchronized level
  p_filt_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(s2_q)));

  // R2: agreement between synchronized and filtered level freezes the output
  p_filt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_q == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/bit_phase_seq.sv
module bit_phase_seq
  import bit_phy_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_high,
  input  logic [CW-1:0] cfg_low,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_hold,
  input  logic          req_valid,
  input  bus_op_e       req_op,
  input  logic          req_bit,
  input  logic          scl_filt_i,
  input  logic          sda_filt_i,
  output logic          req_ready,
  output logic          done,
  output logic          rx_bit,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int TW = CW + 1;

  phase_e        phase_q, phase_d;
  bus_op_e       op_q, op_d;
  logic          bit_q, bit_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          scl_q, scl_d, sda_q, sda_d, done_q, done_d, rx_q, rx_d;
  logic          op_en;

  logic [TW-1:0] high_e, low_e, setup_e, hold_e, t_low, t_high_end;
  logic          edge_op, low_sda;

  function automatic logic [TW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? {{(TW-1){1'b0}}, 1'b1} : {1'b0, v};
  endfunction

  assign high_e  = at_least_one(cfg_high);
  assign low_e   = at_least_one(cfg_low);
  assign setup_e = at_least_one(cfg_setup);
  assign hold_e  = at_least_one(cfg_hold);
  assign t_low   = (low_e > hold_e + setup_e) ? low_e : hold_e + setup_e;
  assign edge_op = (op_q == OP_START) || (op_q == OP_STOP);
  assign t_high_end = edge_op ? setup_e + high_e : high_e;

  always_comb begin
    unique case (op_q)
      OP_START: low_sda = 1'b0;
      OP_STOP:  low_sda = 1'b1;
      OP_WRITE: low_sda = ~bit_q;
      default:  low_sda = 1'b0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    bit_d   = bit_q;
    scl_d   = scl_q;
    sda_d   = sda_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    op_en   = 1'b0;
    cnt_d   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          op_en   = 1'b1;
          op_d    = req_op;
          bit_d   = req_bit;
          cnt_d   = '0;
          phase_d = PH_LOW;
        end
      end
      PH_LOW: begin
        if (cnt_q == hold_e - 1'b1) sda_d = low_sda;
        if ((cnt_q >= t_low - 1'b1) && (!scl_q || !scl_filt_i)) begin
          scl_d   = 1'b0;
          phase_d = PH_RISE;
        end
      end
      PH_RISE: begin
        if (scl_filt_i) begin
          cnt_d   = '0;
          phase_d = PH_HIGH;
        end
      end
      default: begin
        if (edge_op && (cnt_q == setup_e - 1'b1)) sda_d = (op_q == OP_START);
        if (cnt_q == t_high_end - 1'b1) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
          if (op_q != OP_STOP) scl_d = 1'b1;
          if (op_q == OP_READ) rx_d = sda_filt_i;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_START;
      bit_q   <= 1'b0;
      cnt_q   <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      rx_q    <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      scl_q   <= scl_d;
      sda_q   <= sda_d;
      done_q  <= done_d;
      rx_q    <= rx_d;
      if (op_en) begin
        op_q  <= op_d;
        bit_q <= bit_d;
      end
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign done      = done_q;
  assign rx_bit    = rx_q;
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;

  // R4: a clean high clock level moves the engine into its high phase
  p_rise_to_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RISE && scl_filt_i) |=> (phase_q == PH_HIGH));

  // R7: data does not move while the clock is high on a data bit
  p_data_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && $past(phase_q) == PH_HIGH && !edge_op) |-> $stable(sda_q));

  // R9: completion is a single-clock pulse and coincides with idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> req_ready);

  // R5: a finished start leaves both lines pulled low
  p_start_ends_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_START) |-> (scl_q && sda_q));

  // R6: a finished stop leaves both lines released
  p_stop_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && op_q == OP_STOP) |-> (!scl_q && !sda_q));
endmodule

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy #(
  parameter int CW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_scl_high,
  input  logic [CW-1:0] cfg_scl_low,
  input  logic [CW-1:0] cfg_sda_setup,
  input  logic [CW-1:0] cfg_sda_hold,
  input  logic [FW-1:0] cfg_spike_len,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic          req_bit,
  output logic          req_ready,
  output logic          done,
  output logic          rx_bit,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_filt,
  output logic          sda_filt
);
  import bit_phy_pkg::*;

  localparam int NLINES = 2;

  logic              rst_meta_q, rst_int_n;
  logic [NLINES-1:0] raw_w, filt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign raw_w = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_deglitch #(.FW(FW)) u_flt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .len_i  (cfg_spike_len),
      .raw_i  (raw_w[g]),
      .filt_o (filt_w[g])
    );
  end

  assign scl_filt = filt_w[0];
  assign sda_filt = filt_w[1];

  bit_phase_seq #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_high   (cfg_scl_high),
    .cfg_low    (cfg_scl_low),
    .cfg_setup  (cfg_sda_setup),
    .cfg_hold   (cfg_sda_hold),
    .req_valid  (req_valid),
    .req_op     (bus_op_e'(req_op)),
    .req_bit    (req_bit),
    .scl_filt_i (filt_w[0]),
    .sda_filt_i (filt_w[1]),
    .req_ready  (req_ready),
    .done       (done),
    .rx_bit     (rx_bit),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe)
  );
endmodule

// File: tb/i2c_bit_phy_tb_top.sv
`timescale 1ns/1ps
module i2c_bit_phy_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_scl_high, cfg_scl_low, cfg_sda_setup, cfg_sda_hold;
  logic [7:0]  cfg_spike_len;
  logic        req_valid, req_bit;
  logic [1:0]  req_op;
  logic        req_ready, done, rx_bit, scl_oe, sda_oe, scl_filt, sda_filt;
  logic        scl_in, sda_in;
  logic        stretch, slave_low, glitch;

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign scl_in = ~scl_oe & ~stretch;
  assign sda_in = ~sda_oe & ~slave_low & ~glitch;

  i2c_bit_phy dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_scl_high(cfg_scl_high), .cfg_scl_low(cfg_scl_low),
    .cfg_sda_setup(cfg_sda_setup), .cfg_sda_hold(cfg_sda_hold),
    .cfg_spike_len(cfg_spike_len),
    .req_valid(req_valid), .req_op(req_op), .req_bit(req_bit),
    .req_ready(req_ready), .done(done), .rx_bit(rx_bit),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_in(scl_in), .sda_in(sda_in),
    .scl_filt(scl_filt), .sda_filt(sda_filt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- timestamp-based reference model ----------------
  int rcnt, cyc, mph, mop, mbit, t_acc, t_hi;
  int m_scl, m_sda, m_done, m_rx, m_sf, m_df;
  int s1s, s2s, s1d, s2d, run_s, run_d;

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic model_reset();
    mph = 0; mop = 0; mbit = 0; m_scl = 0; m_sda = 0; m_done = 0; m_rx = 1;
    m_sf = 1; m_df = 1; s1s = 1; s2s = 1; s1d = 1; s2d = 1; run_s = 0; run_d = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0;
      model_reset();
    end else if (rcnt < 2) begin
      rcnt++;
      model_reset();
    end else begin
      int raw_s, raw_d, H, L, S, D, LF, tl, hend, lowv;
      H = eff(cfg_scl_high); L = eff(cfg_scl_low); S = eff(cfg_sda_setup);
      D = eff(cfg_sda_hold); LF = eff(cfg_spike_len);
      tl = (L > D + S) ? L : D + S;
      cyc++;
      raw_s = (m_scl == 0 && !stretch) ? 1 : 0;
      raw_d = (m_sda == 0 && !slave_low && !glitch) ? 1 : 0;
      m_done = 0;
      case (mph)
        0: if (req_valid) begin t_acc = cyc; mop = req_op; mbit = req_bit; mph = 1; end
        1: begin
          lowv = (mop == 1) ? 1 : (mop == 2) ? (mbit ? 0 : 1) : 0;
          if (cyc == t_acc + D) m_sda = lowv;
          if (cyc >= t_acc + tl && (m_scl == 0 || m_sf == 0)) begin m_scl = 0; mph = 2; end
        end
        2: if (m_sf == 1) begin t_hi = cyc; mph = 3; end
        default: begin
          hend = (mop <= 1) ? S + H : H;
          if (mop <= 1 && cyc == t_hi + S) m_sda = (mop == 0) ? 1 : 0;
          if (cyc == t_hi + hend) begin
            if (mop != 1) m_scl = 1;
            if (mop == 3) m_rx = m_df;
            m_done = 1;
            mph = 0;
          end
        end
      endcase
      if (s2s != m_sf) run_s++; else run_s = 0;
      if (run_s >= LF) begin m_sf = s2s; run_s = 0; end
      s2s = s1s; s1s = raw_s;
      if (s2d != m_df) run_d++; else run_d = 0;
      if (run_d >= LF) begin m_df = s2d; run_d = 0; end
      s2d = s1d; s1d = raw_d;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk({cur_req, "/R4"}, "scl_oe", scl_oe, m_scl);
      chk({cur_req, "/R7"}, "sda_oe", sda_oe, m_sda);
      chk({cur_req, "/R9"}, "done", done, m_done);
      chk({cur_req, "/R9"}, "req_ready", req_ready, (mph == 0) ? 1 : 0);
      chk({cur_req, "/R8"}, "rx_bit", rx_bit, m_rx);
      chk({cur_req, "/R2"}, "scl_filt", scl_filt, m_sf);
      chk({cur_req, "/R2"}, "sda_filt", sda_filt, m_df);
    end
  end

  task automatic run_op(input logic [1:0] op, input logic b, input int stretch_n,
                        input bit do_glitch, input bit poke);
    int n;
    if (stretch_n > 0) stretch = 1'b1;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin req_valid = 1'b1; req_op = 2'd3; end
    n = 0;
    while (!done) begin
      @(negedge clk);
      req_valid = 1'b0;
      n++;
      if (stretch_n > 0 && n == stretch_n) stretch = 1'b0;
      if (do_glitch && n == 14) glitch = 1'b1;
      if (do_glitch && n == 16) glitch = 1'b0;
    end
    stretch = 1'b0; glitch = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input int h, input int l, input int s, input int d, input int f);
    cfg_scl_high = 16'(h); cfg_scl_low = 16'(l); cfg_sda_setup = 16'(s);
    cfg_sda_hold = 16'(d); cfg_spike_len = 8'(f);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", wd, 150000);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_bit = 1'b0;
    stretch = 1'b0; slave_low = 1'b0; glitch = 1'b0;
    set_cfg(6, 10, 3, 2, 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "scl_oe", scl_oe, 0); chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "req_ready", req_ready, 1); chk("R1", "done", done, 0);
    chk("R1", "rx_bit", rx_bit, 1); chk("R1", "scl_filt", scl_filt, 1);
    chk("R1", "sda_filt", sda_filt, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R5"; run_op(2'd0, 1'b0, 0, 0, 0);
    chk("R5", "scl_oe after start", scl_oe, 1); chk("R5", "sda_oe after start", sda_oe, 1);
    cur_req = "R3"; run_op(2'd2, 1'b1, 0, 0, 0);
    chk("R7", "sda_oe after write 1", sda_oe, 0);
    cur_req = "R7"; run_op(2'd2, 1'b0, 0, 0, 0);
    chk("R7", "sda_oe after write 0", sda_oe, 1);
    cur_req = "R8"; slave_low = 1'b1; run_op(2'd3, 1'b0, 0, 0, 0); slave_low = 1'b0;
    chk("R8", "rx_bit slave low", rx_bit, 0);
    cur_req = "R2"; run_op(2'd3, 1'b0, 0, 1, 0);
    chk("R2", "rx_bit after short glitch", rx_bit, 1);
    cur_req = "R4"; run_op(2'd2, 1'b0, 25, 0, 0);
    cur_req = "R9"; slave_low = 1'b1; run_op(2'd2, 1'b1, 0, 0, 1); slave_low = 1'b0;
    chk("R9", "rx_bit untouched by busy request", rx_bit, 1);
    cur_req = "R6"; run_op(2'd1, 1'b0, 0, 0, 0);
    chk("R6", "scl_oe after stop", scl_oe, 0); chk("R6", "sda_oe after stop", sda_oe, 0);
    repeat (8) @(negedge clk);

    cur_req = "R10"; set_cfg(0, 0, 0, 0, 0);
    run_op(2'd0, 1'b0, 0, 0, 0);
    run_op(2'd2, 1'b0, 0, 0, 0);
    slave_low = 1'b1; run_op(2'd3, 1'b0, 0, 0, 0); slave_low = 1'b0;
    chk("R10", "rx_bit with unit counts", rx_bit, 0);
    run_op(2'd1, 1'b0, 0, 0, 0);
    repeat (8) @(negedge clk);

    cur_req = "R3"; set_cfg(4, 12, 2, 5, 2);
    run_op(2'd0, 1'b0, 0, 0, 0);
    run_op(2'd2, 1'b1, 0, 0, 0);
    run_op(2'd3, 1'b0, 6, 0, 0);
    chk("R8", "rx_bit released bus", rx_bit, 1);
    run_op(2'd1, 1'b0, 0, 0, 0);
    repeat (8) @(negedge clk);
    finish_run();
  end
endmodule